// File: doc/BRIEF.md
# Signed Incremental Integrator Stage

This block is one stage of a digital differential analyzer. It holds a signed integrand `Z` and an unsigned remainder accumulator `Y`, both `W` bits wide. On each iteration strobe it takes a signed unit step of the integration variable (`dx`). It adds `Z` into `Y`, subtracts it, or leaves `Y` alone, depending on that step. The carry or borrow out of the accumulator's top bit becomes a signed unit output step `dy`. The same strobe moves the integrand by a signed unit step `dz`, which keeps `Z` tracking a variable that changes over time.

`Y` is a fraction of one output unit. The integral is the running sum of `dy` plus `Y / 2^W`. Because `|Z| <= 2^(W-1)`, any single iteration moves the integral by less than one unit, so `dy` always fits in {-1, 0, +1}. A synchronous load presets both registers so that a chain of stages can be started from known initial conditions.

Top module: `dda_cell`

## Requirements
- R1: Every increment port uses two wires `{valid, sign}`: bit 1 is valid and bit 0 is sign. `00` means 0, `10` means +1 and `11` means -1. The unused code `01` is treated as 0.
- R2: On a strobe with dx = +1, `Y` becomes `(Y + Z) mod 2^W`, with `Z` taken as signed. `dy` is `floor((Y + Z) / 2^W)`: a carry out of the top bit gives +1 and a borrow caused by a negative `Z` gives -1.
- R3: On a strobe with dx = -1, `Y` becomes `(Y - Z) mod 2^W` and `dy` is `floor((Y - Z) / 2^W)`: a borrow gives -1 and a carry gives +1.
- R4: On a strobe with dx = 0 (code `00` or `01`), `Y` keeps its value and `dy` is 0.
- R5: `dy` is registered. It shows the result of a strobe for exactly the one cycle after the clock edge that took the strobe, and it is `00` in every other cycle.
- R6: On a strobe, `Z` becomes `Z + dz`. The `Y` update of that same strobe uses the value `Z` had before the strobe.
- R7: `Z` saturates at `2^(W-1)-1` and at `-2^(W-1)`. A strobe whose `dz` would pass a limit leaves `Z` at that limit and sets `ovf_o`. `ovf_o` then stays set until a load or a reset.
- R8: While `load_i` is high, a clock edge copies `y_load_i` into `Y` and `z_load_i` into `Z` and clears `ovf_o`. Load takes priority over a strobe in the same cycle, and `dy_o` reads `00` in every cycle in which `load_i` is high.
- R9: Synchronous active-high reset clears `Y`, `Z`, `ovf_o` and `dy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Preset Y and Z from the load ports |
| y_load_i | input | W | Initial remainder value |
| z_load_i | input | W | Initial integrand, two's complement |
| step_i | input | 1 | Iteration strobe |
| dx_i | input | 2 | Integration-variable increment {valid, sign} |
| dz_i | input | 2 | Integrand increment {valid, sign} |
| dy_o | output | 2 | Output increment {valid, sign} |
| y_o | output | W | Current remainder |
| z_o | output | W | Current integrand, two's complement |
| ovf_o | output | 1 | Sticky integrand saturation flag |

## Verification
`Y`, `Z`, `ovf_o` and `dy_o` all change at the first rising edge after the strobe or load is presented. The bench therefore checks them at the falling edge that follows, against a behavioural integer model that it advances once per cycle. The one combinational path, which holds `dy_o` at zero while `load_i` is high, is checked one time unit after `load_i` rises and before the next edge. A `dy_o` pulse that lasts longer than one cycle shows up at the next falling-edge comparison.

// File: rtl/dda_pkg.sv
package dda_pkg;

    // Two-wire signed unit increment: vld=0 -> 0, vld=1 -> +1/-1 by neg
    typedef struct packed {
        logic vld;
        logic neg;
    } tern_t;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2
    } acc_op_e;

    localparam tern_t TERN_ZERO = '{vld: 1'b0, neg: 1'b0};
    localparam tern_t TERN_POS  = '{vld: 1'b1, neg: 1'b0};
    localparam tern_t TERN_NEG  = '{vld: 1'b1, neg: 1'b1};

    function automatic acc_op_e op_from_tern(tern_t t);
        if (!t.vld)     return ACC_HOLD;
        else if (t.neg) return ACC_SUB;
        else            return ACC_ADD;
    endfunction

    // Map the two guard bits above the accumulator to an output step
    function automatic tern_t tern_from_guard(logic [1:0] g);
        case (g)
            2'b01:   return TERN_POS;
            2'b11:   return TERN_NEG;
            default: return TERN_ZERO;
        endcase
    endfunction

endpackage

// File: rtl/dda_yacc.sv
module dda_yacc
    import dda_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    input  tern_t               dx,
    input  logic [W-1:0]        y_load,
    input  logic signed [W-1:0] z_cur,
    output logic [W-1:0]        y_q,
    output tern_t               dy_q
);
    localparam int EW = W + 2;

    acc_op_e              op;
    logic signed [EW-1:0] y_ext;
    logic signed [EW-1:0] z_ext;
    logic signed [EW-1:0] sum;
    tern_t                dy_n;

    assign op    = op_from_tern(dx);
    assign y_ext = $signed({2'b00, y_q});
    assign z_ext = $signed({{2{z_cur[W-1]}}, z_cur});

    always_comb begin
        case (op)
            ACC_ADD: sum = y_ext + z_ext;
            ACC_SUB: sum = y_ext - z_ext;
            default: sum = y_ext;
        endcase
        dy_n = tern_from_guard(sum[EW-1:EW-2]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q  <= '0;
            dy_q <= TERN_ZERO;
        end else if (load) begin
            y_q  <= y_load;
            dy_q <= TERN_ZERO;
        end else if (step) begin
            y_q  <= sum[W-1:0];
            dy_q <= dy_n;
        end else begin
            dy_q <= TERN_ZERO;
        end
    end

    // R4: a zero step leaves the remainder alone and emits nothing
    p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !dx.vld) |=> (y_q == $past(y_q) && !dy_q.vld));

    // R2: adding a non-negative integrand can never borrow
    p_add_no_borrow_r2: assert property (@(posedge clk) disable iff (rst)
        (step && !load && dx.vld && !dx.neg && !z_cur[W-1]) |=> !(dy_q.vld && dy_q.neg));

    // R3: subtracting a non-negative integrand can never carry
    p_sub_no_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && dx.vld && dx.neg && !z_cur[W-1]) |=> !(dy_q.vld && !dy_q.neg));

    // R8: load presets the remainder
    p_load_y_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (y_q == $past(y_load)));

endmodule

// File: rtl/dda_zreg.sv
module dda_zreg
    import dda_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    input  tern_t               dz,
    input  logic [W-1:0]        z_load,
    output logic signed [W-1:0] z_q,
    output logic                ovf_q
);
    localparam logic signed [W-1:0] ZMAX  = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] ZMIN  = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] Z_ONE = {{(W-1){1'b0}}, 1'b1};

    logic signed [W-1:0] z_n;
    logic                hit;

    always_comb begin
        z_n = z_q;
        hit = 1'b0;
        if (dz.vld) begin
            if (!dz.neg) begin
                if (z_q == ZMAX) hit = 1'b1;
                else             z_n = z_q + Z_ONE;
            end else begin
                if (z_q == ZMIN) hit = 1'b1;
                else             z_n = z_q - Z_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            z_q   <= '0;
            ovf_q <= 1'b0;
        end else if (load) begin
            z_q   <= $signed(z_load);
            ovf_q <= 1'b0;
        end else if (step) begin
            z_q   <= z_n;
            ovf_q <= ovf_q | hit;
        end
    end

    // R7: flag is sticky until load
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !load) |=> ovf_q);

    // R7: upward saturation holds the limit and raises the flag
    p_sat_top_r7: assert property (@(posedge clk) disable iff (rst)
        (step && !load && dz.vld && !dz.neg && z_q == ZMAX) |=> (z_q == ZMAX && ovf_q));

    // R6: an inner value moves by exactly one
    p_z_inc_r6: assert property (@(posedge clk) disable iff (rst)
        (step && !load && dz.vld && !dz.neg && z_q != ZMAX) |=> (z_q == $past(z_q) + Z_ONE));

    // R8: load presets the integrand and clears the flag
    p_load_z_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (z_q == $signed($past(z_load)) && !ovf_q));

endmodule

// File: rtl/dda_cell.sv
module dda_cell
    import dda_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] y_load_i,
    input  logic [W-1:0] z_load_i,
    input  logic         step_i,
    input  logic [1:0]   dx_i,
    input  logic [1:0]   dz_i,
    output logic [1:0]   dy_o,
    output logic [W-1:0] y_o,
    output logic [W-1:0] z_o,
    output logic         ovf_o
);
    tern_t               dx_t;
    tern_t               dz_t;
    tern_t               dy_q;
    logic signed [W-1:0] z_cur;
    logic [W-1:0]        y_cur;

    assign dx_t = tern_t'(dx_i);
    assign dz_t = tern_t'(dz_i);

    // Accumulator sees Z before this strobe's dz is applied
    dda_yacc #(.W(W)) u_yacc (
        .clk    (clk),
        .rst    (rst),
        .load   (load_i),
        .step   (step_i),
        .dx     (dx_t),
        .y_load (y_load_i),
        .z_cur  (z_cur),
        .y_q    (y_cur),
        .dy_q   (dy_q)
    );

    dda_zreg #(.W(W)) u_zreg (
        .clk    (clk),
        .rst    (rst),
        .load   (load_i),
        .step   (step_i),
        .dz     (dz_t),
        .z_load (z_load_i),
        .z_q    (z_cur),
        .ovf_q  (ovf_o)
    );

    assign dy_o = load_i ? 2'b00 : dy_q;
    assign y_o  = y_cur;
    assign z_o  = z_cur;

    // R5: without a strobe on the previous edge no increment is shown
    p_dy_single_r5: assert property (@(posedge clk) disable iff (rst)
        !step_i |=> (dy_o[1] == 1'b0));

    // R6: the remainder step uses the pre-strobe integrand
    p_old_z_r6: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && dx_t.vld && !dx_t.neg)
            |=> (y_o == W'($past(y_o) + $past(z_o))));

endmodule

// File: tb/dda_cell_tb_top.sv
module dda_cell_tb_top;
    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;
    localparam int MOD        = 1 << W;
    localparam int ZMAX       = MOD / 2 - 1;
    localparam int ZMIN       = -(MOD / 2);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load = 1'b0;
    logic         step = 1'b0;
    logic [1:0]   dx = 2'b00;
    logic [1:0]   dz = 2'b00;
    logic [W-1:0] yl = '0;
    logic [W-1:0] zl = '0;
    logic [1:0]   dy;
    logic [W-1:0] y;
    logic [W-1:0] z;
    logic         ovf;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dda_cell #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .load_i(load), .y_load_i(yl), .z_load_i(zl),
        .step_i(step), .dx_i(dx), .dz_i(dz), .dy_o(dy), .y_o(y), .z_o(z), .ovf_o(ovf)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int my = 0, mz = 0, mdy = 0, movf = 0;

    localparam logic [1:0] P = 2'b10, N = 2'b11, Z0 = 2'b00, ODD = 2'b01;

    function automatic int tern_val(logic [1:0] t);
        return t[1] ? (t[0] ? -1 : 1) : 0;
    endfunction

    function automatic int sval(logic [W-1:0] v);
        return v[W-1] ? int'(v) - MOD : int'(v);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "Y", int'(y), my);
        chk(tag, "Z", sval(z), mz);
        chk(tag, "ovf", int'(ovf), movf);
        chk(tag, "dy", tern_val(dy), mdy);
    endtask

    task automatic cycle(string tag, bit ld, int yv, int zv, bit st,
                         logic [1:0] dxv, logic [1:0] dzv);
        int t, nz;
        load = ld; yl = yv[W-1:0]; zl = zv[W-1:0];
        step = st; dx = dxv; dz = dzv;
        if (ld) begin
            #1 chk("R8", "dy during load", tern_val(dy), 0);
            my = yv % MOD; mz = zv; movf = 0; mdy = 0;
        end else if (st) begin
            t = my + mz * tern_val(dxv);
            if (t < 0)          begin mdy = -1; t += MOD; end
            else if (t >= MOD)  begin mdy = 1;  t -= MOD; end
            else                mdy = 0;
            my = t;
            nz = mz + tern_val(dzv);
            if (nz > ZMAX)      begin nz = ZMAX; movf = 1; end
            else if (nz < ZMIN) begin nz = ZMIN; movf = 1; end
            mz = nz;
        end else begin
            mdy = 0;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R5 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset wins over a strobe
        step = 1'b1; dx = P; dz = P;
        repeat (3) @(negedge clk);
        rst = 1'b0; step = 1'b0;
        compare_all("R9");

        // R8 load, then R2 carry: 200+100=300 -> dy +1, Y=44
        cycle("R8", 1, 200, 100, 0, Z0, Z0);
        cycle("R2", 0, 0, 0, 1, P, Z0);
        // R3 borrow: 44-100 -> dy -1, Y=200
        cycle("R3", 0, 0, 0, 1, N, Z0);
        // R5: dy drops after one cycle
        cycle("R5", 0, 0, 0, 0, P, Z0);
        // R4 and R1: zero step and the unused code
        cycle("R4", 0, 0, 0, 1, Z0, Z0);
        cycle("R1", 0, 0, 0, 1, ODD, ODD);
        // R2 with negative Z: 10-128 -> dy -1, Y=138
        cycle("R8", 1, 10, -128, 0, Z0, Z0);
        cycle("R2", 0, 0, 0, 1, P, Z0);
        // R3 with negative Z: 138+128 -> dy +1, Y=10
        cycle("R3", 0, 0, 0, 1, N, Z0);
        // R6: old Z used, Z steps
        cycle("R8", 1, 0, 5, 0, Z0, Z0);
        cycle("R6", 0, 0, 0, 1, P, P);
        cycle("R6", 0, 0, 0, 1, P, P);
        cycle("R6", 0, 0, 0, 1, N, N);
        // R7: saturation both ways, sticky flag
        cycle("R8", 1, 0, ZMAX, 0, Z0, Z0);
        cycle("R7", 0, 0, 0, 1, Z0, P);
        cycle("R7", 0, 0, 0, 1, Z0, N);
        cycle("R7", 0, 0, 0, 0, Z0, Z0);
        cycle("R8", 1, 3, ZMIN, 0, Z0, Z0);
        cycle("R7", 0, 0, 0, 1, Z0, N);
        // R8: load beats a strobe in the same cycle and clears ovf
        cycle("R8", 1, 77, -3, 1, P, P);
        cycle("R2", 0, 0, 0, 1, P, Z0);

        // Mixed traffic
        for (int i = 0; i < 600; i++) begin
            cycle("R2", ($urandom % 16) == 0, int'($urandom % MOD),
                  int'($urandom % MOD) - MOD / 2, ($urandom % 4) != 0,
                  2'($urandom), 2'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule